// File: doc/BRIEF.md
# GPIO Interrupt Status and Enable Register Block

This block gathers interrupt events from a set of GPIO lines (24 by default) into a sticky status register. Each line's event arrives as a one-cycle pulse from upstream detection logic that already runs on the bus clock. A per-line enable register then gates the latched flags onto one interrupt request line. Software reads the status register to find out which lines fired. It writes 0 to a flag to acknowledge it and leaves other flags alone by writing 1 to them.

The register interface is a plain memory-mapped port: an address, a write strobe, write data and registered read data. Read data appears one cycle after the address is presented. The status register is at byte offset 0x18 and the enable register is at 0x1C. Any other offset reads as zero and ignores writes. Pin direction plays no part in the gating: an enabled line raises the request whether its pin is configured as an input or an output.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After synchronous reset, every status flag and every enable bit is 0, `irq` is 0 and `bus_rdata` is 0.
- R2: A 1 on `evt_pulse[i]` at a clock edge sets status flag i, which then reads 1 in bit i of offset 0x18. A flag that is 0 means no interrupt has occurred on that line. `bus_rdata` holds the value of the register addressed at the previous clock edge.
- R3: A write to offset 0x18 clears every status flag whose write-data bit is 0 and leaves unchanged every flag whose write-data bit is 1.
- R4: When an event pulse and a clearing write reach the same status flag at the same edge, the flag stays 1.
- R5: Offset 0x1C holds one read/write enable bit per line, in bits 23 to 0 by default.
- R6: Bits 31 to 24 of both registers ignore writes and always read 0.
- R7: A status flag latches its event whether or not its line is enabled.
- R8: `irq` is 1 exactly when at least one line has both its status flag and its enable bit set. It follows register state with no further delay, so it changes in the cycle after the edge that updates that state.
- R9: Reads from any offset other than 0x18 and 0x1C return 0, and writes to such offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous address |
| evt_pulse | input | 24 | One-cycle event pulse per GPIO line |
| irq | output | 1 | Combined masked interrupt request |

## Verification
The assertions assume that event pulses are synchronous to `clk` and stable around its rising edge. They also assume that the write strobe is only sampled at rising edges, so each write moves the state exactly once. The bench drives every input on the falling edge and samples on the falling edge, which keeps to both assumptions. Event pulses are one cycle wide and can be driven in the same cycle as a clearing write, so the collision case is reached legally. The bench sweeps every line through set, masked, enabled, acknowledge-with-1 and clear.

// File: rtl/gis_pkg.sv
package gis_pkg;
  // Target of a register access after address decode
  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_ENABLE = 2'd2
  } gis_sel_e;
endpackage

// File: rtl/gis_decode.sv
module gis_decode
  import gis_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int STATUS_OFS = 'h18,
  parameter int ENABLE_OFS = 'h1C
) (
  input  logic [ADDR_W-1:0] addr,
  output gis_sel_e          sel
);
  localparam logic [ADDR_W-1:0] STATUS_A = ADDR_W'(STATUS_OFS);
  localparam logic [ADDR_W-1:0] ENABLE_A = ADDR_W'(ENABLE_OFS);

  always_comb begin
    if (addr == STATUS_A)      sel = SEL_STATUS;
    else if (addr == ENABLE_A) sel = SEL_ENABLE;
    else                       sel = SEL_NONE;
  end
endmodule

// File: rtl/gis_status_reg.sv
module gis_status_reg #(
  parameter int NUM_LINES = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_hit,
  input  logic [NUM_LINES-1:0] wdata,
  input  logic [NUM_LINES-1:0] evt,
  output logic [NUM_LINES-1:0] status
);
  logic [NUM_LINES-1:0] status_q;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_flag
    logic clr_req;
    assign clr_req = wr_hit & ~wdata[i];

    always_ff @(posedge clk) begin
      if (rst)         status_q[i] <= 1'b0;
      else if (evt[i]) status_q[i] <= 1'b1;
      else if (clr_req) status_q[i] <= 1'b0;
    end

    // R2 and R4: an event always leaves the flag set
    p_evt_sets_r2: assert property (@(posedge clk) disable iff (rst)
      evt[i] |=> status_q[i]);
    // R3: a written 0 clears the flag when no event competes
    p_zero_clears_r3: assert property (@(posedge clk) disable iff (rst)
      (wr_hit && !wdata[i] && !evt[i]) |=> !status_q[i]);
    // R3: a written 1 leaves the flag unchanged
    p_one_keeps_r3: assert property (@(posedge clk) disable iff (rst)
      (wr_hit && wdata[i] && !evt[i]) |=> $stable(status_q[i]));
  end

  // R9: without a status write or event the register holds
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!wr_hit && evt == '0) |=> $stable(status_q));

  assign status = status_q;
endmodule

// File: rtl/gis_enable_reg.sv
module gis_enable_reg #(
  parameter int NUM_LINES = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_hit,
  input  logic [NUM_LINES-1:0] wdata,
  output logic [NUM_LINES-1:0] enable
);
  logic [NUM_LINES-1:0] enable_q;

  always_ff @(posedge clk) begin
    if (rst)         enable_q <= '0;
    else if (wr_hit) enable_q <= wdata;
  end

  // R5: written value is held from the next cycle
  p_enable_load_r5: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> enable_q == $past(wdata));
  // R9: no write, no change
  p_enable_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> $stable(enable_q));

  assign enable = enable_q;
endmodule

// File: rtl/gis_readback.sv
module gis_readback
  import gis_pkg::*;
#(
  parameter int NUM_LINES = 24,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  gis_sel_e             sel,
  input  logic [NUM_LINES-1:0] status,
  input  logic [NUM_LINES-1:0] enable,
  output logic [DATA_W-1:0]    rdata
);
  localparam int RSV_W = DATA_W - NUM_LINES;

  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      unique case (sel)
        SEL_STATUS: rdata_q <= {{RSV_W{1'b0}}, status};
        SEL_ENABLE: rdata_q <= {{RSV_W{1'b0}}, enable};
        default:    rdata_q <= '0;
      endcase
    end
  end

  // R9: unmapped offsets read zero one cycle later
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_NONE) |=> rdata_q == '0);
  // R6: reserved upper bits never read as 1
  p_rsv_zero_r6: assert property (@(posedge clk) disable iff (rst)
    rdata_q[DATA_W-1:NUM_LINES] == '0);

  assign rdata = rdata_q;
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gis_pkg::*;
#(
  parameter int NUM_LINES  = 24,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 8,
  parameter int STATUS_OFS = 'h18,
  parameter int ENABLE_OFS = 'h1C
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_LINES-1:0] evt_pulse,
  output logic                 irq
);
  gis_sel_e             sel;
  logic [NUM_LINES-1:0] status;
  logic [NUM_LINES-1:0] enable;
  logic                 unused_rsv_wdata;

  assign unused_rsv_wdata = ^bus_wdata[DATA_W-1:NUM_LINES];

  gis_decode #(
    .ADDR_W    (ADDR_W),
    .STATUS_OFS(STATUS_OFS),
    .ENABLE_OFS(ENABLE_OFS)
  ) u_decode (
    .addr(bus_addr),
    .sel (sel)
  );

  gis_status_reg #(.NUM_LINES(NUM_LINES)) u_status (
    .clk   (clk),
    .rst   (rst),
    .wr_hit(bus_wr && sel == SEL_STATUS),
    .wdata (bus_wdata[NUM_LINES-1:0]),
    .evt   (evt_pulse),
    .status(status)
  );

  gis_enable_reg #(.NUM_LINES(NUM_LINES)) u_enable (
    .clk   (clk),
    .rst   (rst),
    .wr_hit(bus_wr && sel == SEL_ENABLE),
    .wdata (bus_wdata[NUM_LINES-1:0]),
    .enable(enable)
  );

  gis_readback #(
    .NUM_LINES(NUM_LINES),
    .DATA_W   (DATA_W)
  ) u_readback (
    .clk   (clk),
    .rst   (rst),
    .sel   (sel),
    .status(status),
    .enable(enable),
    .rdata (bus_rdata)
  );

  assign irq = |(status & enable);

  // R8: a request needs a pending flag
  p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (rst)
    irq |-> status != '0);
  // R8: a fully cleared enable register silences the request
  p_irq_masked_r8: assert property (@(posedge clk) disable iff (rst)
    (enable == '0) |-> !irq);
  // R7: an event on an enabled line raises the request next cycle
  p_evt_enabled_irq_r7: assert property (@(posedge clk) disable iff (rst)
    ((evt_pulse & enable) != '0 && !(bus_wr && sel == SEL_ENABLE)) |=> irq);
endmodule

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N    = 24;
  localparam int DW   = 32;
  localparam int AW   = 8;
  localparam logic [AW-1:0] A_STAT = 8'h18;
  localparam logic [AW-1:0] A_EN   = 8'h1C;
  localparam logic [DW-1:0] LMASK  = 32'h00FF_FFFF;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [N-1:0]  evt_pulse = '0;
  logic          irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_pulse(evt_pulse), .irq(irq)
  );

  task automatic chk(input string req, input logic [DW-1:0] got,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    step();
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_chk(input string req, input logic [AW-1:0] a,
                        input logic [DW-1:0] exp);
    bus_addr = a;
    step();
    chk(req, bus_rdata, exp);
  endtask

  task automatic pulse(input logic [N-1:0] e);
    evt_pulse = e;
    step();
    evt_pulse = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] exp_en;
    logic [N-1:0] exp_st;
    @(negedge clk);
    bus_addr = A_STAT;
    repeat (3) step();
    // R1: reset state on the outputs
    chk("R1 irq in reset", {31'd0, irq}, 32'd0);
    chk("R1 rdata in reset", bus_rdata, 32'd0);
    rst = 1'b0;
    rd_chk("R1 status after reset", A_STAT, 32'd0);
    rd_chk("R1 enable after reset", A_EN, 32'd0);

    // R5/R6: enable register round trip, reserved bits dropped
    wr(A_EN, 32'hFFFF_FFFF);
    rd_chk("R6 enable reserved", A_EN, LMASK);
    for (int k = 0; k < 4; k++) begin
      logic [DW-1:0] pat;
      pat = 32'hA5C3_5A3C ^ (32'h0101_0101 << k);
      wr(A_EN, pat);
      rd_chk("R5 enable pattern", A_EN, pat & LMASK);
    end
    wr(A_EN, 32'd0);
    chk("R8 irq idle", {31'd0, irq}, 32'd0);

    // Sweep every line
    for (int i = 0; i < N; i++) begin
      exp_st = N'(1) << i;
      evt_pulse = exp_st;
      #1;
      chk("R8 irq before edge", {31'd0, irq}, 32'd0);
      step();
      evt_pulse = '0;
      chk("R7 irq with line disabled", {31'd0, irq}, 32'd0);
      rd_chk("R2 status set", A_STAT, {8'd0, exp_st});
      wr(A_EN, {8'd0, exp_st});
      chk("R8 irq enabled line", {31'd0, irq}, 32'd1);
      exp_en = ~exp_st;
      wr(A_EN, {8'd0, exp_en});
      chk("R8 irq other lines only", {31'd0, irq}, 32'd0);
      wr(A_EN, LMASK);
      wr(A_STAT, 32'hFFFF_FFFF);
      rd_chk("R3 write 1 keeps", A_STAT, {8'd0, exp_st});
      chk("R8 irq still pending", {31'd0, irq}, 32'd1);
      wr(A_STAT, {8'd0, ~exp_st});
      chk("R8 irq after clear", {31'd0, irq}, 32'd0);
      rd_chk("R3 write 0 clears", A_STAT, 32'd0);
      wr(A_EN, 32'd0);
    end

    // R3: selective clear of several flags
    pulse(24'hF0_0F0F);
    wr(A_STAT, 32'h00F0_00FF);
    rd_chk("R3 selective clear", A_STAT, 32'h00F0_000F);
    wr(A_STAT, 32'd0);

    // R4: event and clear on the same bit at the same edge
    pulse(24'h00_0028);
    evt_pulse = 24'h00_0020;
    wr(A_STAT, 32'd0);
    evt_pulse = '0;
    rd_chk("R4 event beats clear", A_STAT, 32'h0000_0020);
    wr(A_STAT, 32'd0);

    // R6: reserved status bits
    pulse(24'h80_0001);
    wr(A_STAT, 32'hFF00_0000);
    rd_chk("R6 status reserved", A_STAT, 32'd0);

    // R9: unmapped offsets
    wr(A_EN, 32'h0012_3456);
    pulse(24'h00_0100);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h19, 32'h0000_0000);
    wr(8'h20, 32'h0000_0000);
    wr(8'h00, 32'hFFFF_FFFF);
    rd_chk("R9 unmapped read 0x10", 8'h10, 32'd0);
    rd_chk("R9 unmapped read 0x1D", 8'h1D, 32'd0);
    rd_chk("R9 unmapped read 0xFF", 8'hFF, 32'd0);
    rd_chk("R9 status untouched", A_STAT, 32'h0000_0100);
    rd_chk("R9 enable untouched", A_EN, 32'h0012_3456);
    chk("R8 irq from line 8", {31'd0, irq}, 32'd0);
    wr(A_EN, 32'h0000_0100);
    chk("R8 irq line 8 enabled", {31'd0, irq}, 32'd1);

    // R1: reset clears everything again
    rst = 1'b1;
    step();
    chk("R1 irq after second reset", {31'd0, irq}, 32'd0);
    rst = 1'b0;
    rd_chk("R1 status after second reset", A_STAT, 32'd0);
    rd_chk("R1 enable after second reset", A_EN, 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule